// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits beside an ADC and screens every conversion result as it arrives. Software programs two limits, a lower bound called the above-limit and an upper bound called the below-limit. When a result satisfies the window condition, a sticky flag is set. The flag drives an interrupt line and can also be polled. No per-sample software work is needed.

No mode bit selects between inside-window and outside-window detection. The choice follows from the limit values alone. When the below-limit is larger than the above-limit, a result flags if it lies strictly between them. Otherwise a result flags if it lies strictly below the below-limit or strictly above the above-limit.

A byte-wide register port exposes each limit as a set of bytes. The same port shows the flag and clears it. The result width is a parameter and must be a multiple of eight.

Top module: `adc_win_top`

## Requirements
- R1: After reset every above-limit byte reads 0xFF, every below-limit byte reads 0x00, and the flag and `winIrq` are 0.
- R2: When the below-limit is greater than the above-limit, a valid result sets the flag if and only if it is strictly greater than the above-limit and strictly less than the below-limit. The flag is visible on `winIrq` one clock after the strobe.
- R3: When the below-limit is less than or equal to the above-limit, a valid result sets the flag if and only if it is strictly less than the below-limit or strictly greater than the above-limit.
- R4: With the reset limit values, no result value sets the flag.
- R5: Once set, the flag stays set through later non-matching results. Writing a 1 to bit 0 of address 0 leaves it unchanged.
- R6: Writing a 0 to bit 0 of address 0 clears the flag on the next clock. If a matching result arrives in the same cycle as that write, the flag is set instead.
- R7: The register map, with NB = DATA_W/8, is as follows. Address 0 holds the flag in bit 0, and its other bits read 0. Above-limit byte k, where byte 0 is the least significant, is at address 1+k. Below-limit byte k is at address 1+NB+k. All limit bytes are readable and writable. Other addresses read 0 and ignore writes.
- R8: A result is compared against the limit values held before any write in its own cycle. A limit that is only partly rewritten is used as it stands.
- R9: Without a result-valid strobe the flag never becomes set, and `winIrq` always equals the flag bit read at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resultValid | input | 1 | One-cycle strobe marking a new conversion result |
| resultData | input | DATA_W | Conversion result |
| regAddr | input | ADDR_W | Register port address |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from address |
| winIrq | output | 1 | Window interrupt request (the flag) |

## Verification
The bench builds the block with DATA_W = 8 and ADDR_W = 2. This makes every result value only 256 wide and puts the whole map in three addresses. Every result value is swept against an 8-by-8 grid of limit pairs. The grid includes equal limits, adjacent limits, 0 and 255, so both window shapes and all their boundary points are covered exhaustively. The same small setup makes it cheap to collide a limit write or a flag clear with a result strobe in the same cycle.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

  // Decoded register access, handed from control to datapath
  typedef struct packed {
    logic       hitFlag;   // address 0
    logic       hitLimit;  // address inside a limit range
    logic       selLt;     // limit range is the below-limit
    logic [3:0] byteIdx;   // byte within the selected limit
    logic       wrEn;      // write this cycle
    logic       clrFlag;   // write of 0 to the flag bit
  } winStrobe_t;

endpackage

// File: rtl/adc_win_ctrl.sv
module adc_win_ctrl
  import adc_win_pkg::*;
#(
  parameter int NB     = 2,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output winStrobe_t        strobe
);

  localparam int LAST_ADDR = 2 * NB;

  logic [31:0] addrExt;
  assign addrExt = 32'(regAddr);

  always_comb begin
    strobe          = '0;
    strobe.hitFlag  = (addrExt == 32'd0);
    strobe.hitLimit = (addrExt >= 32'd1) && (addrExt <= 32'(LAST_ADDR));
    strobe.selLt    = strobe.hitLimit && (addrExt > 32'(NB));
    if (strobe.hitLimit) begin
      strobe.byteIdx = strobe.selLt ? 4'(addrExt - 32'd1 - 32'(NB))
                                    : 4'(addrExt - 32'd1);
    end
    strobe.wrEn    = regWrEn;
    strobe.clrFlag = regWrEn && strobe.hitFlag && !regWrData[0];
  end

endmodule

// File: rtl/adc_win_dp.sv
module adc_win_dp
  import adc_win_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NB     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobe,
  input  logic [7:0]        regWrData,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] resultData,
  output logic [7:0]        regRdData,
  output logic              winFlag,
  output logic [DATA_W-1:0] gtLimit,
  output logic [DATA_W-1:0] ltLimit
);

  // Limit byte registers, one pair per result byte
  for (genvar b = 0; b < NB; b++) begin : g_limByte
    logic wrGt, wrLt;
    assign wrGt = strobe.wrEn && strobe.hitLimit && !strobe.selLt && (strobe.byteIdx == 4'(b));
    assign wrLt = strobe.wrEn && strobe.hitLimit &&  strobe.selLt && (strobe.byteIdx == 4'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        gtLimit[b*8 +: 8] <= 8'hFF;
        ltLimit[b*8 +: 8] <= 8'h00;
      end else begin
        if (wrGt) gtLimit[b*8 +: 8] <= regWrData;
        if (wrLt) ltLimit[b*8 +: 8] <= regWrData;
      end
    end
  end

  // Window shape follows the ordering of the two limits
  logic insideMode, aboveGt, belowLt, winMatch;
  assign insideMode = ltLimit > gtLimit;
  assign aboveGt    = resultData > gtLimit;
  assign belowLt    = resultData < ltLimit;
  assign winMatch   = insideMode ? (aboveGt && belowLt) : (aboveGt || belowLt);

  // Sticky flag: a hardware set outranks a software clear
  always_ff @(posedge clk) begin
    if (!rstN)                         winFlag <= 1'b0;
    else if (resultValid && winMatch)  winFlag <= 1'b1;
    else if (strobe.clrFlag)           winFlag <= 1'b0;
  end

  always_comb begin
    regRdData = '0;
    if (strobe.hitFlag) begin
      regRdData = {7'b0, winFlag};
    end else if (strobe.hitLimit) begin
      for (int b = 0; b < NB; b++) begin
        if (strobe.byteIdx == 4'(b))
          regRdData = strobe.selLt ? ltLimit[b*8 +: 8] : gtLimit[b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/adc_win_top.sv
module adc_win_top
  import adc_win_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [DATA_W-1:0] resultData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              winIrq
);

  localparam int NB = DATA_W / 8;

  winStrobe_t        strobe;
  logic [DATA_W-1:0] gtLimit;
  logic [DATA_W-1:0] ltLimit;

  adc_win_ctrl #(.NB(NB), .ADDR_W(ADDR_W)) u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  adc_win_dp #(.DATA_W(DATA_W), .NB(NB)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrData   (regWrData),
    .resultValid (resultValid),
    .resultData  (resultData),
    .regRdData   (regRdData),
    .winFlag     (winIrq),
    .gtLimit     (gtLimit),
    .ltLimit     (ltLimit)
  );

endmodule

// File: rtl/adc_win_chk.sv
module adc_win_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              resultValid,
  input logic [DATA_W-1:0] resultData,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic              winIrq,
  input logic [DATA_W-1:0] gtLimit,
  input logic [DATA_W-1:0] ltLimit
);

  function automatic logic windowHit(input logic [DATA_W-1:0] r, g, l);
    if (l > g) return (r > g) && (r < l);
    return (r < l) || (r > g);
  endfunction

  logic hitNow, clrReq;
  assign hitNow = resultValid && windowHit(resultData, gtLimit, ltLimit);
  assign clrReq = regWrEn && (regAddr == '0) && !regWrData[0];

  assert_set_on_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> winIrq);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (winIrq && !clrReq) |=> winIrq);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !hitNow) |=> !winIrq);

  assert_no_spurious_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!winIrq && !hitNow) |=> !winIrq);

  assert_limits_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(gtLimit) && $stable(ltLimit)));

  assert_flag_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == '0) |-> (regRdData == {7'b0, winIrq}));

endmodule

bind adc_win_top adc_win_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resultValid (resultValid),
  .resultData  (resultData),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .winIrq      (winIrq),
  .gtLimit     (gtLimit),
  .ltLimit     (ltLimit)
);

// File: tb/adc_win_top_bench.sv
module adc_win_top_bench;

  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          resultValid = 1'b0;
  logic [DW-1:0] resultData = '0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic          winIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_win_top #(.DATA_W(DW), .ADDR_W(AW)) u_adc_win_top (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultData(resultData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .winIrq(winIrq)
  );

  function automatic bit expHit(input int r, g, l);
    if (l > g) return (r > g) && (r < l);
    return (r < l) || (r > g);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input int d);
    @(negedge clk);
    regAddr = AW'(a); regWrData = 8'(d); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input string req, input int a, input int exp);
    regAddr = AW'(a);
    #1;
    check(req, int'(regRdData), exp);
  endtask

  task automatic sendResult(input int r);
    @(negedge clk);
    resultValid = 1'b1; resultData = DW'(r);
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic clearFlag();
    regWrite(0, 0);
  endtask

  int gridVals[8] = '{0, 1, 2, 50, 127, 128, 254, 255};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead("R1", 1, 255);
    regRead("R1", 2, 0);
    regRead("R1", 0, 0);
    check("R1", int'(winIrq), 0);

    // R4: reset limits never match
    for (int r = 0; r < 256; r++) begin
      sendResult(r);
      check("R4", int'(winIrq), 0);
    end

    // R7 map: write/read both limits, unmapped address
    regWrite(1, 8'hA5); regRead("R7", 1, 8'hA5);
    regWrite(2, 8'h3C); regRead("R7", 2, 8'h3C);
    regWrite(3, 8'h77);
    regRead("R7", 3, 0);
    regRead("R7", 1, 8'hA5);
    regRead("R7", 2, 8'h3C);
    regRead("R7", 0, 0);

    // R2 / R3 exhaustive sweep over a limit grid
    for (int gi = 0; gi < 8; gi++) begin
      for (int li = 0; li < 8; li++) begin
        regWrite(1, gridVals[gi]);
        regWrite(2, gridVals[li]);
        for (int r = 0; r < 256; r++) begin
          sendResult(r);
          check(gridVals[li] > gridVals[gi] ? "R2" : "R3", int'(winIrq),
                int'(expHit(r, gridVals[gi], gridVals[li])));
          regAddr = '0; #1;
          check("R9", int'(regRdData), int'(winIrq));
          if (winIrq) clearFlag();
        end
      end
    end

    // Inside window 10..20 for remaining checks
    regWrite(1, 10);
    regWrite(2, 20);
    // R5 sticky, write 1 ignored
    sendResult(15);
    check("R5", int'(winIrq), 1);
    sendResult(30);
    sendResult(5);
    check("R5", int'(winIrq), 1);
    regWrite(0, 1);
    check("R5", int'(winIrq), 1);
    // R6 clear
    clearFlag();
    check("R6", int'(winIrq), 0);
    // R6 set wins over simultaneous clear
    @(negedge clk);
    resultValid = 1'b1; resultData = 8'd12;
    regAddr = '0; regWrData = 8'h00; regWrEn = 1'b1;
    @(negedge clk);
    resultValid = 1'b0; regWrEn = 1'b0;
    check("R6", int'(winIrq), 1);
    clearFlag();
    check("R6", int'(winIrq), 0);

    // R8: same-cycle limit write does not affect the compare
    @(negedge clk);
    resultValid = 1'b1; resultData = 8'd30;
    regAddr = 2'd2; regWrData = 8'd40; regWrEn = 1'b1;
    @(negedge clk);
    resultValid = 1'b0; regWrEn = 1'b0;
    check("R8", int'(winIrq), 0);
    regRead("R8", 2, 40);
    sendResult(30);
    check("R8", int'(winIrq), 1);
    clearFlag();

    // R9: no strobe, no set, even with a matching value on the bus
    resultData = 8'd25;
    repeat (4) @(negedge clk);
    check("R9", int'(winIrq), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule